// File: doc/BRIEF.md
# Tri-Port Bus Exchange Datapath

This block joins a CPU address/data port (X) to two memory data ports: an even bank (Y) and an odd bank (Z). Each memory port has two holding registers of its own. A write register keeps X data that is bound for that port. A read register keeps that port's data for return to X. Each of the four registers has its own capture enable. Three controls set which pins drive at any moment: a direction input, an even/odd select, and an active-low output enable for each byte. Each bidirectional pin group appears as three signals: an input vector, an output vector and a per-byte drive-enable vector.

The capture enables do not depend on the path select. Because of this, a controller can interleave the two banks. It drives one bank's held read data onto X while it loads the other bank, then flips the select on the next access. If all four enables stay high, the block acts as a plain transceiver with one clock of latency.

The latches are built as clocked registers. While an enable is high, the register loads on every rising clock edge. When the enable goes low, the register keeps the value from the last edge at which the enable was high.

Top module: `bus_exchanger_3p`

## Requirements
- R1: After an active-low reset, all four holding registers read zero, so `x_out`, `y_out` and `z_out` are 0x0000.
- R2: When `cap_x2y` is high at a rising edge, `y_out` shows the `x_in` value from that edge. While `cap_x2y` is low, `y_out` keeps its value.
- R3: When `cap_x2z` is high at a rising edge, `z_out` shows the `x_in` value from that edge. While `cap_x2z` is low, `z_out` keeps its value.
- R4: When `cap_y2x` (or `cap_z2x`) is high at a rising edge, the even (or odd) read register loads `y_in` (or `z_in`). While its enable is low, that register keeps its value.
- R5: `x_out` shows the even read register when `sel_even` is 1 and the odd read register when `sel_even` is 0.
- R6: `x_oe[1]` (upper byte, bits 15:8) is 1 only when `dir_tx` is 0 and `oe_hi_n` is 0. `x_oe[0]` (lower byte, bits 7:0) is 1 only when `dir_tx` is 0 and `oe_lo_n` is 0.
- R7: `y_oe` bytes are enabled only when `dir_tx` is 1, `sel_even` is 1 and the matching active-low byte enable is 0. `z_oe` bytes follow the same rule with `sel_even` at 0. The memory port that is not selected is never enabled.
- R8: With both `oe_hi_n` and `oe_lo_n` at 1, all six drive-enable bits are 0.
- R9: `sel_even` has no effect on any capture. The odd read register loads while the even register drives X, and the reverse also works.
- R10: With all four capture enables held high, the block passes data in both directions one cycle after the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_in | input | 16 | Data arriving on the CPU port |
| x_out | output | 16 | Data driven onto the CPU port |
| x_oe | output | 2 | CPU port drive enables, [1]=upper byte |
| y_in | input | 16 | Data arriving on the even memory port |
| y_out | output | 16 | Data driven onto the even memory port |
| y_oe | output | 2 | Even port drive enables, [1]=upper byte |
| z_in | input | 16 | Data arriving on the odd memory port |
| z_out | output | 16 | Data driven onto the odd memory port |
| z_oe | output | 2 | Odd port drive enables, [1]=upper byte |
| sel_even | input | 1 | 1 selects even port Y, 0 selects odd port Z |
| dir_tx | input | 1 | 1: X in, selected memory port out; 0: X out |
| oe_hi_n | input | 1 | Active-low enable for the upper byte |
| oe_lo_n | input | 1 | Active-low enable for the lower byte |
| cap_x2y | input | 1 | Load X data into the even write register |
| cap_x2z | input | 1 | Load X data into the odd write register |
| cap_y2x | input | 1 | Load Y data into the even read register |
| cap_z2x | input | 1 | Load Z data into the odd read register |

## Verification
Two things can happen in the same cycle: one bank's read register drives X, and a capture loads the other bank. The bench provokes this in two steps. First it loads the even read register. Then it holds `sel_even` at 1 and raises only `cap_z2x` with fresh odd-port data. In that cycle, `x_out` must still show the even word. The bench then sets `sel_even` to 0 without raising any enable, and `x_out` must now show the odd word captured earlier. This shows that the capture took effect even though the odd port was not selected.

// File: rtl/bus_exchanger_3p.sv
module bus_exchanger_3p #(
  parameter int BYTE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*BYTE-1:0] x_in,
  output logic [2*BYTE-1:0] x_out,
  output logic [1:0]        x_oe,
  input  logic [2*BYTE-1:0] y_in,
  output logic [2*BYTE-1:0] y_out,
  output logic [1:0]        y_oe,
  input  logic [2*BYTE-1:0] z_in,
  output logic [2*BYTE-1:0] z_out,
  output logic [1:0]        z_oe,
  input  logic              sel_even,
  input  logic              dir_tx,
  input  logic              oe_hi_n,
  input  logic              oe_lo_n,
  input  logic              cap_x2y,
  input  logic              cap_x2z,
  input  logic              cap_y2x,
  input  logic              cap_z2x
);
  localparam int W = 2 * BYTE;

  logic [W-1:0] wr_y, wr_z, rd_y, rd_z;
  logic [1:0]   byte_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_y <= '0;
      wr_z <= '0;
      rd_y <= '0;
      rd_z <= '0;
    end else begin
      if (cap_x2y) wr_y <= x_in;
      if (cap_x2z) wr_z <= x_in;
      if (cap_y2x) rd_y <= y_in;
      if (cap_z2x) rd_z <= z_in;
    end
  end

  assign byte_en = {~oe_hi_n, ~oe_lo_n};

  assign x_out = sel_even ? rd_y : rd_z;
  assign y_out = wr_y;
  assign z_out = wr_z;

  assign x_oe = byte_en & {2{~dir_tx}};
  assign y_oe = byte_en & {2{dir_tx & sel_even}};
  assign z_oe = byte_en & {2{dir_tx & ~sel_even}};
endmodule

// File: rtl/bus_exchanger_3p_chk.sv
module bus_exchanger_3p_chk #(
  parameter int BYTE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*BYTE-1:0] x_in,
  input logic [2*BYTE-1:0] x_out,
  input logic [1:0]        x_oe,
  input logic [2*BYTE-1:0] y_in,
  input logic [2*BYTE-1:0] y_out,
  input logic [1:0]        y_oe,
  input logic [2*BYTE-1:0] z_out,
  input logic [1:0]        z_oe,
  input logic              sel_even,
  input logic              dir_tx,
  input logic              oe_hi_n,
  input logic              oe_lo_n,
  input logic              cap_x2y,
  input logic              cap_x2z,
  input logic              cap_y2x
);
  logic up;
  always_ff @(posedge clk) up <= rst_n;

  // R2
  y_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_x2y |=> y_out == $past(x_in));
  // R2
  y_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_x2y |=> $stable(y_out));
  // R3
  z_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_x2z |=> $stable(z_out));
  // R5
  even_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $past(rst_n) && $past(cap_y2x) && sel_even) |-> x_out == $past(y_in));
  // R6
  x_quiet_on_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_tx |-> x_oe == 2'b00);
  // R7
  mem_quiet_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_tx |-> (y_oe == 2'b00 && z_oe == 2'b00));
  // R7
  one_bank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|y_oe, |z_oe}) <= 1);
  // R8
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_hi_n && oe_lo_n) |-> {x_oe, y_oe, z_oe} == 6'd0);
endmodule

bind bus_exchanger_3p bus_exchanger_3p_chk #(.BYTE(BYTE)) i_chk (
  .clk(clk), .rst_n(rst_n), .x_in(x_in), .x_out(x_out), .x_oe(x_oe),
  .y_in(y_in), .y_out(y_out), .y_oe(y_oe), .z_out(z_out), .z_oe(z_oe),
  .sel_even(sel_even), .dir_tx(dir_tx), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
  .cap_x2y(cap_x2y), .cap_x2z(cap_x2z), .cap_y2x(cap_y2x)
);

// File: tb/test_bus_exchanger_3p.sv
module test_bus_exchanger_3p;
  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] x_in = 0, y_in = 0, z_in = 0;
  logic [15:0] x_out, y_out, z_out;
  logic [1:0]  x_oe, y_oe, z_oe;
  logic sel_even = 0, dir_tx = 0, oe_hi_n = 1, oe_lo_n = 1;
  logic cap_x2y = 0, cap_x2z = 0, cap_y2x = 0, cap_z2x = 0;

  always #5 clk = ~clk;

  bus_exchanger_3p i_bus_exchanger_3p (
    .clk(clk), .rst_n(rst_n),
    .x_in(x_in), .x_out(x_out), .x_oe(x_oe),
    .y_in(y_in), .y_out(y_out), .y_oe(y_oe),
    .z_in(z_in), .z_out(z_out), .z_oe(z_oe),
    .sel_even(sel_even), .dir_tx(dir_tx), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
    .cap_x2y(cap_x2y), .cap_x2z(cap_x2z), .cap_y2x(cap_y2x), .cap_z2x(cap_z2x)
  );

  typedef struct {
    logic [15:0] xo, yo, zo;
    logic [1:0]  xe, ye, ze;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_wy = 0, m_wz = 0, m_ry = 0, m_rz = 0;

  task automatic check(input string tag, input logic [15:0] xo, yo, zo,
                       input logic [1:0] xe, ye, ze, input item_t e);
    checks++;
    if ({xo, yo, zo, xe, ye, ze} !== {e.xo, e.yo, e.zo, e.xe, e.ye, e.ze}) begin
      fails++;
      $display("FAIL %s: got x=%h/%b y=%h/%b z=%h/%b exp x=%h/%b y=%h/%b z=%h/%b",
               tag, xo, xe, yo, ye, zo, ze, e.xo, e.xe, e.yo, e.ye, e.zo, e.ze);
    end
  endtask

  task automatic step(input logic [15:0] xi, yi, zi, input logic pe, dt, ohn, oln,
                      input logic cxy, cxz, cyx, czx, input string tag);
    item_t e;
    @(negedge clk);
    x_in = xi; y_in = yi; z_in = zi;
    sel_even = pe; dir_tx = dt; oe_hi_n = ohn; oe_lo_n = oln;
    cap_x2y = cxy; cap_x2z = cxz; cap_y2x = cyx; cap_z2x = czx;
    if (cxy) m_wy = xi;
    if (cxz) m_wz = xi;
    if (cyx) m_ry = yi;
    if (czx) m_rz = zi;
    e.xo = pe ? m_ry : m_rz;
    e.yo = m_wy;
    e.zo = m_wz;
    e.xe = {~dt & ~ohn, ~dt & ~oln};
    e.ye = {dt & pe & ~ohn, dt & pe & ~oln};
    e.ze = {dt & ~pe & ~ohn, dt & ~pe & ~oln};
    e.tag = tag;
    q.push_back(e);
  endtask

  initial forever begin
    @(posedge clk);
    #3;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      check(e.tag, x_out, y_out, z_out, x_oe, y_oe, z_oe, e);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
    end
  end

  initial begin
    item_t z0;
    z0.xo = 0; z0.yo = 0; z0.zo = 0; z0.xe = 0; z0.ye = 0; z0.ze = 0; z0.tag = "R1";
    repeat (3) @(posedge clk);
    #3;
    check("R1 reset", x_out, y_out, z_out, x_oe, y_oe, z_oe, z0);
    @(negedge clk);
    rst_n = 1;

    // R2 write even register, then hold with new X data
    step(16'h1234, 16'h0, 16'h0, 1, 1, 0, 0, 1, 0, 0, 0, "R2 load");
    step(16'hBEEF, 16'h0, 16'h0, 1, 1, 0, 0, 0, 0, 0, 0, "R2 hold");
    // R3 write odd register, even untouched
    step(16'hA5C3, 16'h0, 16'h0, 0, 1, 0, 0, 0, 1, 0, 0, "R3 load");
    step(16'h0F0F, 16'h0, 16'h0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 hold");
    // R4 read captures and hold
    step(16'h0, 16'h5555, 16'h6666, 1, 0, 0, 0, 0, 0, 1, 1, "R4 load");
    step(16'h0, 16'h7777, 16'h8888, 1, 0, 0, 0, 0, 0, 0, 0, "R4 hold");
    // R5 path select on X
    step(16'h0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 odd");
    step(16'h0, 16'h0, 16'h0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 even");
    // R6 R7 R8 every control combination
    for (int i = 0; i < 16; i++)
      step(16'h0, 16'h0, 16'h0, i[3], i[2], i[1], i[0], 0, 0, 0, 0,
           (i[1] & i[0]) ? "R8 all off" : (i[2] ? "R7 mem oe" : "R6 x oe"));
    // R9 capture odd while even drives X, then the reverse
    step(16'h0, 16'hC0DE, 16'h0, 1, 0, 0, 0, 0, 0, 1, 0, "R9 even load");
    step(16'h0, 16'h0, 16'hFACE, 1, 0, 0, 0, 0, 0, 0, 1, "R9 odd cap while even");
    step(16'h0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 odd shown");
    step(16'h0, 16'h1357, 16'h0, 0, 0, 0, 0, 0, 0, 1, 0, "R9 even cap while odd");
    step(16'h0, 16'h0, 16'h0, 1, 0, 0, 0, 0, 0, 0, 0, "R9 even shown");
    // R10 transparent transceiver
    for (int i = 0; i < 6; i++)
      step(16'h1111 * i[15:0], 16'h2468 + i[15:0], 16'h9BDF - i[15:0],
           i[0], i[1], 0, 0, 1, 1, 1, 1, "R10 transparent");
    repeat (3) @(posedge clk);
    #4;
    done = 1;
    summary();
  end
endmodule